// File: doc/BRIEF.md
# Output Drive Current Calibration Servo

This block tunes the strength of current-mode output drivers. It keeps a six-bit working code. Each bit of the code switches on one leg of a driver bank, and the legs are binary-weighted (bit 0 is the 1x leg, bit 5 is the 32x leg). A comparator looks at a replica pad and tells the block whether that pad's voltage is above or below the reference. The comparator reaches the block as a single bit. Once every 32 clock cycles the block reads that bit and moves the code one step toward balance. Once the loop reaches balance it keeps stepping, and so it dithers around the point where the two voltages are equal.

The lane drivers do not use the working code directly. They use a shadow copy, and that copy changes only when a load is requested. A load never changes the lane code while the interface is transmitting, so the drivers cannot glitch mid-word. If a load is requested during transmission, it waits and is applied on the first idle cycle. A settled flag goes high when the servo has reversed direction on four evaluations in a row.

Top module: `drv_cal_servo`

## Requirements
- R1: While reset is asserted, and right after it is released, the working code and the lane code both hold 32 and settled is low.
- R2: The working code changes only on evaluation edges. An evaluation happens on every 32nd rising clock edge, and the first one is the 32nd rising edge after reset is released.
- R3: At an evaluation the code steps by exactly one, using the value cmp_hi had at the rising edge two edges earlier. A 1 on cmp_hi (pad above reference) steps the code up. A 0 steps it down.
- R4: The working code saturates. At 63 an up step leaves it at 63, and at 0 a down step leaves it at 0. It never wraps.
- R5: If load_req is high and tx_busy is low at a rising edge, the lane code takes the working code value from just before that edge.
- R6: The lane code never changes at an edge where tx_busy is high. A load_req seen while busy stays pending and is applied at the first edge where tx_busy is low.
- R7: After an evaluation, settled is high exactly when the last four evaluations each reversed the direction of the one before. Any evaluation in the same direction as the previous one clears settled.
- R8: If the comparator is high only while the code is below a target T, the code climbs to T and then alternates between T-1 and T.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_hi | input | 1 | Comparator result, 1 when the replica pad is above the reference |
| tx_busy | input | 1 | High while the interface is transmitting |
| load_req | input | 1 | Request to copy the working code to the lanes |
| work_code | output | 6 | Working calibration code, drives the replica legs |
| lane_code | output | 6 | Shadow code that drives all lane drivers |
| settled | output | 1 | Four consecutive direction reversals observed |

## Verification
The servo is run under four comparator patterns. A constant high runs the code into the upper limit, and a constant low runs it into the lower limit; together these separate a stepping error from a wrap at either end. A closed loop that drives cmp_hi from the code against a target shows whether the servo hunts and dithers correctly, and whether settled rises. Releasing the loop to a constant level afterwards shows that settled clears. Load requests are issued both while the interface is idle and while it is busy, which separates an immediate copy from a deferred one.

// File: rtl/drv_cal_servo.sv
module drv_cal_servo #(
  parameter int CODE_W   = 6,
  parameter int TICK_DIV = 32,
  parameter int SETTLE_N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_hi,
  input  logic              tx_busy,
  input  logic              load_req,
  output logic [CODE_W-1:0] work_code,
  output logic [CODE_W-1:0] lane_code,
  output logic              settled
);
  localparam int TICK_W = $clog2(TICK_DIV);
  localparam int ALT_W  = $clog2(SETTLE_N + 1);
  localparam logic [CODE_W-1:0] MID  = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CODE_W-1:0] MAXC = {CODE_W{1'b1}};
  localparam logic [TICK_W-1:0] LAST = TICK_W'(TICK_DIV - 1);
  localparam logic [ALT_W-1:0]  ALT_TOP = ALT_W'(SETTLE_N);

  logic [TICK_W-1:0] div_cnt;
  logic              cmp_s1, cmp_s2;
  logic              pend;
  logic              last_up, have_dir;
  logic [ALT_W-1:0]  alt_cnt;
  logic              tick, want_load, reversed;

  assign tick      = (div_cnt == LAST);
  assign want_load = pend | load_req;
  assign reversed  = have_dir & (cmp_s2 != last_up);
  assign settled   = (alt_cnt == ALT_TOP);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_cnt <= '0;
      cmp_s1  <= 1'b0;
      cmp_s2  <= 1'b0;
    end else begin
      div_cnt <= tick ? '0 : div_cnt + TICK_W'(1);
      cmp_s1  <= cmp_hi;
      cmp_s2  <= cmp_s1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      work_code <= MID;
      last_up   <= 1'b0;
      have_dir  <= 1'b0;
      alt_cnt   <= '0;
    end else if (tick) begin
      if (cmp_s2 && work_code != MAXC)
        work_code <= work_code + CODE_W'(1);
      else if (!cmp_s2 && work_code != '0)
        work_code <= work_code - CODE_W'(1);
      last_up  <= cmp_s2;
      have_dir <= 1'b1;
      if (!reversed)
        alt_cnt <= '0;
      else if (alt_cnt != ALT_TOP)
        alt_cnt <= alt_cnt + ALT_W'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lane_code <= MID;
      pend      <= 1'b0;
    end else begin
      if (want_load && !tx_busy)
        lane_code <= work_code;
      pend <= want_load & tx_busy;
    end
endmodule

module drv_cal_servo_chk #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              cmp_s2,
  input logic              tx_busy,
  input logic              load_req,
  input logic [CODE_W-1:0] work_code,
  input logic [CODE_W-1:0] lane_code,
  input logic              settled
);
  localparam logic [CODE_W-1:0] MAXC = {CODE_W{1'b1}};

  // R2
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(work_code));

  // R3
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cmp_s2 && work_code != MAXC) |=> work_code == CODE_W'($past(work_code) + 1));

  // R3
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cmp_s2 && work_code != '0) |=> work_code == CODE_W'($past(work_code) - 1));

  // R4
  top_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cmp_s2 && work_code == MAXC) |=> work_code == MAXC);

  // R4
  floor_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cmp_s2 && work_code == '0) |=> work_code == '0);

  // R5
  idle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && !tx_busy) |=> lane_code == $past(work_code));

  // R6
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |=> $stable(lane_code));

  // R7
  settle_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(settled));
endmodule

bind drv_cal_servo drv_cal_servo_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cmp_s2(cmp_s2),
  .tx_busy(tx_busy), .load_req(load_req), .work_code(work_code),
  .lane_code(lane_code), .settled(settled)
);

// File: tb/drv_cal_servo_bench.sv
module drv_cal_servo_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp_hi = 1'b0, tx_busy = 1'b0, load_req = 1'b0;
  logic [5:0] work_code, lane_code;
  logic       settled;

  int checks = 0, fails = 0, cycles = 0;
  bit loop_mode = 0;
  int target = 20;

  always #4 clk = ~clk;

  drv_cal_servo u_drv_cal_servo (
    .clk(clk), .rst_n(rst_n), .cmp_hi(cmp_hi), .tx_busy(tx_busy),
    .load_req(load_req), .work_code(work_code), .lane_code(lane_code),
    .settled(settled)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_code, m_lane, m_edges, m_alt;
  bit m_pend, m_have, m_last;
  bit pipe[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_code = 32; m_lane = 32; m_edges = 0; m_alt = 0;
      m_pend = 0; m_have = 0; m_last = 0;
      pipe = {1'b0, 1'b0};
    end else begin
      bit d;
      bit go;
      m_edges++;
      d = pipe.pop_front();
      pipe.push_back(cmp_hi);
      go = (m_pend || load_req) && !tx_busy;
      m_pend = (m_pend || load_req) && tx_busy;
      if (go) m_lane = m_code;
      if (m_edges % 32 == 0) begin
        if (m_have && d != m_last) m_alt = (m_alt < 4) ? m_alt + 1 : 4;
        else m_alt = 0;
        m_have = 1; m_last = d;
        if (d) m_code = (m_code < 63) ? m_code + 1 : 63;
        else m_code = (m_code > 0) ? m_code - 1 : 0;
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk("R2 R3 work_code", int'(work_code), m_code);
      chk("R5 R6 lane_code", int'(lane_code), m_lane);
      chk("R7 settled", int'(settled), int'(m_alt >= 4));
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (loop_mode) cmp_hi = (int'(work_code) < target);
    end
  endtask

  initial begin
    static int w;
    step(3);
    chk("R1 reset work", int'(work_code), 32);
    chk("R1 reset lane", int'(lane_code), 32);
    chk("R1 reset settled", int'(settled), 0);
    rst_n = 1'b1;
    step(1);
    chk("R1 after release", int'(work_code), 32);

    // R2: first evaluation on the 32nd edge
    step(30);
    chk("R2 before first tick", int'(work_code), 32);
    step(1);
    chk("R2 first tick down", int'(work_code), 31);

    // R3 R4: drive to the top
    cmp_hi = 1'b1;
    step(32 * 36);
    chk("R4 top clamp", int'(work_code), 63);

    // R3 R4: drive to the floor
    cmp_hi = 1'b0;
    step(32 * 68);
    chk("R4 floor clamp", int'(work_code), 0);

    // R5: idle load
    w = int'(work_code);
    load_req = 1'b1;
    step(1);
    load_req = 1'b0;
    chk("R5 idle load", int'(lane_code), w);

    // R8 R7: closed loop hunting
    loop_mode = 1;
    step(32 * 40);
    chk("R7 settled in loop", int'(settled), 1);
    checks++;
    if (!(work_code == 6'(target) || work_code == 6'(target - 1))) begin
      fails++;
      $display("FAIL R8 dither actual %0d expected %0d or %0d", work_code, target - 1, target);
    end

    // R6: load while busy is deferred
    tx_busy = 1'b1;
    w = int'(lane_code);
    load_req = 1'b1;
    step(1);
    load_req = 1'b0;
    step(70);
    chk("R6 frozen while busy", int'(lane_code), w);
    w = int'(work_code);
    tx_busy = 1'b0;
    step(1);
    chk("R6 pending applied", int'(lane_code), w);

    // R7: same-direction evaluations clear settled
    loop_mode = 0;
    cmp_hi = 1'b1;
    step(32 * 4);
    chk("R7 cleared", int'(settled), 0);

    step(5);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    checks++; fails++;
    $display("FAIL watchdog actual %0d expected below 150000", cycles);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule